// File: doc/BRIEF.md
# Byte-Port Sample FIFO with Thresholds

This block buffers 16-bit converter results and hands them to a host over an 8-bit port. Each converter strobe stores one sample as two bytes. The host reads the bytes back one at a time, low byte first, in arrival order. The default capacity is 4096 bytes, which holds 2048 samples.

A command write can empty the buffer and selects how the byte port behaves. In data mode the port reads stored bytes. In program mode the port writes the two 16-bit thresholds, one byte per write, starting straight after an empty command. A status byte reports the level flags:

- empty
- near-full: free bytes at or below the near-full threshold
- full
- near-empty: stored bytes at or below the near-empty threshold

The same status byte carries three sticky event bits: threshold crossing, end of scan and data lost. Reading the status byte clears the event bits. An interrupt line follows the event bits selected by a control byte.

Top module: `sample_byte_fifo`

## Requirements
- R1: After asynchronous reset the buffer is empty, both thresholds are 0, the port is in program mode, `stat_o` reads 0x41 (empty plus near-empty), `port_rdata_o` reads 0 and `irq_o` is low.
- R2: Each accepted sample occupies two bytes. The host reads the bytes low then high, and samples come out in the order they were written.
- R3: The capacity is DEPTH_BYTES bytes. Status bit 2 (full) is set while fewer than two bytes are free. A sample strobed while full is dropped, and status bit 5 (data lost) is set.
- R4: A port read while the buffer is empty returns 0 and does not move the read position, so the next stored byte is still read correctly.
- R5: A sample write and a port read in the same cycle both take effect, and the occupancy changes by +1. Whether the sample is accepted is decided from the occupancy before that cycle.
- R6: A command write with bit 6 set empties the buffer and restarts threshold loading. Command bit 0 selects data mode (1) or program mode (0).
- R7: In program mode, port writes load these fields in order: near-empty low byte, near-empty high byte, near-full low byte, near-full high byte. Writes beyond the fourth are ignored. Port writes in data mode change neither the stored data nor the thresholds.
- R8: Status bit 1 (near-full) is set while free bytes ≤ the near-full threshold. Status bit 6 (near-empty) is set while stored bytes ≤ the near-empty threshold. Status bit 0 (empty) is set while no bytes are stored.
- R9: Status bit 3 (threshold event) is set when the near-full condition goes from false to true. Status bit 4 (end-of-scan event) is set by a pulse on `eos_i`. Both bits hold until they are cleared.
- R10: A status read returns the event bits as they stand and clears bits 3 to 5 at the end of that cycle. An event arriving in the same cycle as the read survives the clear.
- R11: `irq_o` is high while (bit 3 and control bit 3) or (bit 4 and control bit 4).
- R12: In program mode a port read returns 0 and removes no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Sample strobe from the converter |
| smp_data_i | input | 16 | Sample value |
| eos_i | input | 1 | End-of-scan event pulse |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 8 | Command byte: bit 6 empties the buffer, bit 0 selects data mode |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_i | input | 8 | Control byte: bit 3 enables the threshold interrupt, bit 4 enables the end-of-scan interrupt |
| port_we_i | input | 1 | Byte port write strobe (threshold load) |
| port_wdata_i | input | 8 | Byte port write data |
| port_re_i | input | 1 | Byte port read strobe |
| port_rdata_o | output | 8 | Head byte, valid in the cycle of the read strobe |
| stat_re_i | input | 1 | Status read strobe, clears the event bits |
| stat_o | output | 8 | Status byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Timing of each result relative to its stimulus:
- **Read data:** `port_rdata_o` and `stat_o` are combinational from state, so the byte that a read strobe consumes is valid in the same cycle as the strobe.
- **Occupancy and level flags:** these move on the edge that samples a strobe.
- **Threshold event:** it comes from an edge detector, so it appears one edge after the near-full flag rises.
- **Event clear:** the clear caused by a status read lands on the edge that ends the read cycle.

How the bench keeps to that timing:
- It drives every operation on a falling edge and holds it for one full cycle.
- It samples outputs one time unit after that falling edge.
- It always lets at least one further rising edge pass before looking at status, so each value is checked in the cycle it is due.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int CMD_CLR_BIT    = 6;
  localparam int CMD_DATA_BIT   = 0;
  localparam int CTL_THR_IE_BIT = 3;
  localparam int CTL_EOS_IE_BIT = 4;

  typedef struct packed {
    logic lost;
    logic eos;
    logic thr;
  } evt_t;
endpackage

// File: rtl/sbf_store.sv
module sbf_store #(
  parameter  int DEPTH_BYTES = 4096,
  localparam int AW = $clog2(DEPTH_BYTES),
  localparam int CW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [15:0]   data_i,
  input  logic          pop_i,
  output logic [7:0]    byte_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          lost_o
);
  localparam int WORDS = DEPTH_BYTES / 2;
  localparam logic [AW-2:0] WR_ONE = 1;
  localparam logic [AW-1:0] RD_ONE = 1;

  logic [15:0]   mem_q [WORDS];
  logic [AW-2:0] wr_q;   // write side is always word aligned
  logic [AW-1:0] rd_q;   // byte position
  logic [CW-1:0] cnt_q;
  logic [15:0]   head;
  logic          accept, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q > CW'(DEPTH_BYTES - 2));
  assign accept  = push_i & ~full_o & ~clr_i;
  assign pop_ok  = pop_i & ~empty_o & ~clr_i;
  assign lost_o  = push_i & full_o & ~clr_i;
  assign count_o = cnt_q;

  assign head   = mem_q[rd_q[AW-1:1]];
  assign byte_o = empty_o ? 8'h00 : (rd_q[0] ? head[15:8] : head[7:0]);

  always_ff @(posedge clk_i)
    if (accept) mem_q[wr_q] <= data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (accept) wr_q <= wr_q + WR_ONE;
      if (pop_ok) rd_q <= rd_q + RD_ONE;
      cnt_q <= cnt_q + (accept ? CW'(2) : CW'(0)) - (pop_ok ? CW'(1) : CW'(0));
    end
  end

  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH_BYTES));
  a_r3_drop_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clr_i) |=> cnt_q == $past(cnt_q));
  a_r4_empty_read_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !clr_i) |=> $stable(rd_q));
  a_r5_push_and_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && pop_i && !empty_o && !clr_i) |=> cnt_q == $past(cnt_q) + CW'(1));
endmodule

// File: rtl/sbf_thresh.sv
module sbf_thresh #(
  parameter int DEPTH_BYTES = 4096,
  parameter int CW = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          mode_i,
  input  logic          wr_i,
  input  logic [7:0]    byte_i,
  input  logic [CW-1:0] count_i,
  output logic          nfull_o,
  output logic          nempty_o
);
  logic [2:0]  idx_q;
  logic [15:0] ne_q, nf_q;
  logic [31:0] used, free;

  assign used     = 32'(count_i);
  assign free     = 32'(DEPTH_BYTES) - used;
  assign nfull_o  = free <= {16'h0, nf_q};
  assign nempty_o = used <= {16'h0, ne_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      ne_q  <= '0;
      nf_q  <= '0;
    end else if (clr_i) begin
      idx_q <= '0;
    end else if (wr_i && !mode_i && idx_q != 3'd4) begin
      case (idx_q)
        3'd0:    ne_q[7:0]  <= byte_i;
        3'd1:    ne_q[15:8] <= byte_i;
        3'd2:    nf_q[7:0]  <= byte_i;
        default: nf_q[15:8] <= byte_i;
      endcase
      idx_q <= idx_q + 3'd1;
    end
  end

  a_r7_load_index_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= 3'd4);
  a_r7_extra_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !mode_i && idx_q == 3'd4 && !clr_i) |=> ($stable(ne_q) && $stable(nf_q)));
  a_r7_data_mode_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && mode_i) |=> ($stable(ne_q) && $stable(nf_q)));
endmodule

// File: rtl/sbf_events.sv
module sbf_events
  import sbf_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nfull_i,
  input  logic eos_i,
  input  logic lost_i,
  input  logic rd_clr_i,
  input  logic thr_ie_i,
  input  logic eos_ie_i,
  output evt_t evt_o,
  output logic irq_o
);
  logic nf_d;
  evt_t evt_q, set;

  assign set.thr  = nfull_i & ~nf_d;
  assign set.eos  = eos_i;
  assign set.lost = lost_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nf_d  <= 1'b0;
      evt_q <= '0;
    end else begin
      nf_d  <= nfull_i;
      evt_q <= (rd_clr_i ? evt_t'('0) : evt_q) | set;  // new events beat the clear
    end
  end

  assign evt_o = evt_q;
  assign irq_o = (evt_q.thr & thr_ie_i) | (evt_q.eos & eos_ie_i);

  a_r9_eos_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eos_i |=> evt_q.eos);
  a_r9_eos_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_clr_i && evt_q.eos) |=> evt_q.eos);
  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !eos_i && !lost_i && !nfull_i) |=> evt_q == '0);
  a_r11_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (evt_q.thr || evt_q.eos));
endmodule

// File: rtl/sample_byte_fifo.sv
module sample_byte_fifo
  import sbf_pkg::*;
#(
  parameter  int DEPTH_BYTES = 4096,
  localparam int AW = $clog2(DEPTH_BYTES),
  localparam int CW = AW + 1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        smp_valid_i,
  input  logic [15:0] smp_data_i,
  input  logic        eos_i,
  input  logic        cmd_we_i,
  input  logic [7:0]  cmd_i,
  input  logic        ctrl_we_i,
  input  logic [7:0]  ctrl_i,
  input  logic        port_we_i,
  input  logic [7:0]  port_wdata_i,
  input  logic        port_re_i,
  output logic [7:0]  port_rdata_o,
  input  logic        stat_re_i,
  output logic [7:0]  stat_o,
  output logic        irq_o
);
  logic          mode_q, thr_ie_q, eos_ie_q;
  logic          clr, pop;
  logic [7:0]    head_byte;
  logic [CW-1:0] fill;
  logic          empty, full, lost, nfull, nempty;
  evt_t          evt;
  logic          unused_bits;

  assign unused_bits = ^{cmd_i[7], cmd_i[5:1], ctrl_i[7:5], ctrl_i[2:0]};
  assign clr = cmd_we_i & cmd_i[CMD_CLR_BIT];
  assign pop = port_re_i & mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      thr_ie_q <= 1'b0;
      eos_ie_q <= 1'b0;
    end else begin
      if (cmd_we_i) mode_q <= cmd_i[CMD_DATA_BIT];
      if (ctrl_we_i) begin
        thr_ie_q <= ctrl_i[CTL_THR_IE_BIT];
        eos_ie_q <= ctrl_i[CTL_EOS_IE_BIT];
      end
    end
  end

  sbf_store #(.DEPTH_BYTES(DEPTH_BYTES)) u_store (
    .clk_i, .rst_ni, .clr_i(clr), .push_i(smp_valid_i), .data_i(smp_data_i),
    .pop_i(pop), .byte_o(head_byte), .count_o(fill), .empty_o(empty),
    .full_o(full), .lost_o(lost)
  );

  sbf_thresh #(.DEPTH_BYTES(DEPTH_BYTES), .CW(CW)) u_thresh (
    .clk_i, .rst_ni, .clr_i(clr), .mode_i(mode_q), .wr_i(port_we_i),
    .byte_i(port_wdata_i), .count_i(fill), .nfull_o(nfull), .nempty_o(nempty)
  );

  sbf_events u_events (
    .clk_i, .rst_ni, .nfull_i(nfull), .eos_i, .lost_i(lost), .rd_clr_i(stat_re_i),
    .thr_ie_i(thr_ie_q), .eos_ie_i(eos_ie_q), .evt_o(evt), .irq_o
  );

  assign port_rdata_o = mode_q ? head_byte : 8'h00;
  assign stat_o = {1'b0, nempty, evt.lost, evt.eos, evt.thr, full, nfull, empty};

  a_r12_prog_read_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_re_i && !mode_q && !cmd_we_i && !smp_valid_i) |=> $stable(fill));
  a_r6_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[CMD_CLR_BIT]) |=> empty);
endmodule

// File: tb/sim_sample_byte_fifo.sv
module sim_sample_byte_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic smp_valid = 0, eos = 0, cmd_we = 0, ctrl_we = 0, port_we = 0, port_re = 0, stat_re = 0;
  logic [15:0] smp_data = '0;
  logic [7:0] cmd = '0, ctrl = '0, wdata = '0;
  logic [7:0] rdata, stat;
  logic irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  sample_byte_fifo #(.DEPTH_BYTES(D)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid), .smp_data_i(smp_data),
    .eos_i(eos), .cmd_we_i(cmd_we), .cmd_i(cmd), .ctrl_we_i(ctrl_we), .ctrl_i(ctrl),
    .port_we_i(port_we), .port_wdata_i(wdata), .port_re_i(port_re), .port_rdata_o(rdata),
    .stat_re_i(stat_re), .stat_o(stat), .irq_o(irq)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] mq[$];
  bit m_mode = 0, m_thr = 0, m_eos = 0, m_lost = 0, m_nfp = 0, m_tie = 0, m_eie = 0;
  int m_ne = 0, m_nf = 0, m_idx = 0;

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit nf_now();
    return (D - mq.size()) <= m_nf;
  endfunction

  function automatic void model_after();
    bit nf = nf_now();
    if (nf && !m_nfp) m_thr = 1;
    m_nfp = nf;
  endfunction

  function automatic logic [7:0] exp_stat();
    int n = mq.size();
    return {1'b0, n <= m_ne, m_lost, m_eos, m_thr, (D - n) < 2, nf_now(), n == 0};
  endfunction

  task automatic push(logic [15:0] v);
    @(negedge clk); smp_valid = 1; smp_data = v;
    @(negedge clk); smp_valid = 0;
    if (D - mq.size() >= 2) begin mq.push_back(v[7:0]); mq.push_back(v[15:8]); end
    else m_lost = 1;
    model_after();
  endtask

  task automatic rd_byte(string req);
    logic [7:0] e;
    @(negedge clk); port_re = 1; #1;
    e = (m_mode && mq.size() > 0) ? mq[0] : 8'h00;
    check(req, rdata, e);
    @(negedge clk); port_re = 0;
    if (m_mode && mq.size() > 0) void'(mq.pop_front());
    model_after();
  endtask

  task automatic rd_stat(string req);
    @(negedge clk); stat_re = 1; #1;
    check(req, stat, exp_stat());
    check({req, " irq"}, {7'b0, irq}, {7'b0, (m_thr & m_tie) | (m_eos & m_eie)});
    @(negedge clk); stat_re = 0;
    m_thr = 0; m_eos = 0; m_lost = 0;
    model_after();
  endtask

  task automatic both(logic [15:0] v, string req);
    logic [7:0] e;
    bit room;
    @(negedge clk); smp_valid = 1; smp_data = v; port_re = 1; #1;
    e = (m_mode && mq.size() > 0) ? mq[0] : 8'h00;
    check(req, rdata, e);
    room = (D - mq.size()) >= 2;
    @(negedge clk); smp_valid = 0; port_re = 0;
    if (m_mode && mq.size() > 0) void'(mq.pop_front());
    if (room) begin mq.push_back(v[7:0]); mq.push_back(v[15:8]); end else m_lost = 1;
    model_after();
  endtask

  task automatic do_cmd(logic [7:0] b);
    @(negedge clk); cmd_we = 1; cmd = b;
    @(negedge clk); cmd_we = 0;
    if (b[6]) begin mq.delete(); m_idx = 0; end
    m_mode = b[0];
    model_after();
  endtask

  task automatic pwrite(logic [7:0] b);
    @(negedge clk); port_we = 1; wdata = b;
    @(negedge clk); port_we = 0;
    if (!m_mode && m_idx < 4) begin
      case (m_idx)
        0: m_ne = (m_ne & 'hff00) | b;
        1: m_ne = (m_ne & 'h00ff) | (int'(b) << 8);
        2: m_nf = (m_nf & 'hff00) | b;
        default: m_nf = (m_nf & 'h00ff) | (int'(b) << 8);
      endcase
      m_idx++;
    end
    model_after();
  endtask

  task automatic do_ctrl(logic [7:0] b);
    @(negedge clk); ctrl_we = 1; ctrl = b;
    @(negedge clk); ctrl_we = 0;
    m_tie = b[3]; m_eie = b[4];
  endtask

  task automatic eos_pulse();
    @(negedge clk); eos = 1;
    @(negedge clk); eos = 0;
    m_eos = 1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 status", stat, 8'h41);
    check("R1 rdata", rdata, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R7: program ne=2, nf=4, extra write ignored
    do_cmd(8'h40);
    pwrite(8'h02); pwrite(8'h00); pwrite(8'h04); pwrite(8'h00); pwrite(8'hff);
    do_cmd(8'h01);
    do_ctrl(8'h08);
    rd_stat("R7 after program");

    // R8/R9/R11: fill sweep, status at every level
    for (int k = 0; k < D/2; k++) begin
      push(16'ha000 + 16'(k * 'h0111));
      rd_stat("R8 R9 fill sweep");
    end
    push(16'hdead);
    rd_stat("R3 overflow lost");

    // R2: drain in order
    for (int k = 0; k < D; k++) begin
      rd_byte("R2 drain order");
      if (k == D/2) rd_stat("R8 mid drain");
    end
    rd_byte("R4 empty read zero");
    rd_byte("R4 empty read zero again");
    push(16'h1234);
    rd_byte("R4 pointer kept");
    rd_byte("R4 pointer kept hi");
    rd_stat("R4 status");

    // R5: simultaneous write and read
    push(16'h5a6b);
    both(16'h7c8d, "R5 read during write");
    rd_stat("R5 count");
    for (int k = 0; k < 3; k++) rd_byte("R5 order after overlap");
    both(16'h9eaf, "R5 overlap on empty");
    rd_byte("R5 second"); rd_byte("R5 third");

    // R7: data-mode write has no effect
    pwrite(8'h55);
    rd_byte("R7 data write ignored");
    rd_stat("R7 thresholds kept");

    // R12: program-mode read returns zero, removes nothing
    push(16'hc3d4);
    do_cmd(8'h00);
    rd_byte("R12 prog read zero");
    pwrite(8'h09);
    do_cmd(8'h01);
    rd_byte("R12 byte kept lo"); rd_byte("R12 byte kept hi");
    rd_stat("R12 status");

    // R6: clear command
    push(16'h0101); push(16'h0202); push(16'h0303);
    do_cmd(8'h41);
    rd_stat("R6 cleared status");
    rd_byte("R6 cleared read");

    // R6/R7: reprogram after clear, ne=6 nf=10
    do_cmd(8'h40);
    pwrite(8'h06); pwrite(8'h00); pwrite(8'h0a); pwrite(8'h00);
    do_cmd(8'h01);
    rd_stat("R6 reprogram");
    for (int k = 0; k < 4; k++) begin
      push(16'(k + 'h40));
      rd_stat("R8 second thresholds");
    end

    // R9/R10/R11: end-of-scan
    do_ctrl(8'h18);
    eos_pulse();
    rd_stat("R11 eos irq");
    rd_stat("R10 eos cleared");
    do_ctrl(8'h00);
    eos_pulse();
    rd_stat("R11 eos masked");
    // R10: event in the same cycle as the read survives
    do_ctrl(8'h10);
    @(negedge clk); eos = 1; stat_re = 1; #1;
    check("R10 same cycle pre", stat, exp_stat());
    @(negedge clk); eos = 0; stat_re = 0;
    m_thr = 0; m_lost = 0; m_eos = 1;
    check("R11 irq after survive", {7'b0, irq}, 8'h01);
    rd_stat("R10 event survived");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule